// File: doc/BRIEF.md
# Quadrature Incremental Encoder Emulator

This block turns a stream of absolute angle samples into the three signals of an incremental encoder: two quadrature phases, A and B, and a once-per-turn index pulse, I. A downstream motor controller or counter can then track the shaft position with a plain quadrature decoder, as if a physical optical or magnetic encoder were fitted. The angle arrives as an `ANG_W`-bit word qualified by a valid strobe. It is reduced to either a fine grid of 2^`FINE_RES` steps per turn or a coarse grid of half that many. The default is 2048 steps, or 512 full A/B cycles, per turn.

A programmable hysteresis band keeps sensor noise from making the outputs dither around a step boundary. When the angle jumps by more than one step between samples, as happens at high speed, the block does not skip. It walks its output position toward the new target one step at a time, at most one step per step-rate tick, always taking the shorter way around the circle. No counts are lost. A fault input overrides everything and parks all three outputs high. After reset the outputs stay low until the first valid angle, which loads the output position directly without emitting any steps.

Top module: `quad_enc_emu`

## Requirements
- R1: The step index is `angle_i >> (ANG_W-FINE_RES)` when `res10_i`=0 (N = 2^FINE_RES steps) and `angle_i >> (ANG_W-FINE_RES+1)` when `res10_i`=1 (N = 2^(FINE_RES-1) steps). Each full A/B cycle spans 4 steps.
- R2: For output position p, with phase p mod 4 = 0,1,2,3, {A,B} is 00, 10, 11, 01. A therefore leads B as the position increases. When `dir_inv_i`=1, A and B are swapped, so B leads for an increasing position.
- R3: I is high at position 0. When `idx_narrow_i`=0 it is also high at positions 1 and N-1, giving 3 steps in total. When `idx_narrow_i`=1 it is high at position 0 only.
- R4: At fine resolution, `hys_code_i` 00, 01, 10 and 11 give a hysteresis H of 3, 2, 1 and 0 steps. A new sample replaces the target only when its shortest circular distance from the current target exceeds H.
- R5: At coarse resolution, `hys_code_i` 00, 01, 10 and 11 give H = 2, 1, 0 and 3 coarse steps. The rule of R4 applies.
- R6: The output position changes by exactly one step, and only on a step-rate tick, which occurs once every `TICK_DIV` clocks. The step goes in the shorter circular direction toward the target. When the target is exactly N/2 away, the position counts up.
- R7: After any sequence of targets, including a new target that arrives while a move is still in progress, the output position ends equal to the last accepted target and no count is lost.
- R8: Stepping between N-1 and 0 is one adjacent step in either direction.
- R9: While `fault_i` is sampled high, A, B and I are all high from the next clock onward. Position tracking continues underneath, and the outputs show the tracked position once the fault clears.
- R10: After reset, A, B and I are low until the first valid angle. That sample sets the output position directly, with no intermediate steps, and the outputs show it one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| angle_i | input | ANG_W | Absolute angle, full scale is one turn |
| angle_vld_i | input | 1 | Qualifies `angle_i` for one clock |
| res10_i | input | 1 | 0: fine grid, 1: coarse grid (half the steps) |
| dir_inv_i | input | 1 | Swaps A and B |
| idx_narrow_i | input | 1 | 0: 3-step index, 1: 1-step index |
| hys_code_i | input | 2 | Hysteresis code, decoded per resolution |
| fault_i | input | 1 | Forces A, B and I high |
| qa_o | output | 1 | Quadrature phase A |
| qb_o | output | 1 | Quadrature phase B |
| qi_o | output | 1 | Index pulse |

## Verification
The bench drives target jumps across the N-1/0 seam and a jump of exactly half a turn. A design that wrapped the wrong way would unwind almost a full turn, and one that broke the tie the wrong way would count down. It re-targets while a long move is still running, which catches a stepper that latches its destination only once. It also decodes A/B continuously, so an output change that skips a phase or comes faster than the tick shows up as a lost or illegal count. It walks every hysteresis code at both resolutions, one step inside and one step beyond the band. A design that shared one code table between the resolutions, or used >= instead of >, either moves too early or sticks.

// File: rtl/qe_pkg.sv
package qe_pkg;

   // Hysteresis band in steps of the selected grid.
   // Fine grid:   00->3, 01->2, 10->1, 11->0
   // Coarse grid: 00->2, 01->1, 10->0, 11->3  (modulo-4 rotation of 2-code)
   function automatic logic [1:0] hys_steps(input logic [1:0] code, input logic coarse);
      logic [1:0] base;
      base = coarse ? 2'd2 : 2'd3;
      return 2'(base - code);
   endfunction

   // Step mask for the selected grid
   function automatic int unsigned grid_mask(input int unsigned pw, input logic coarse);
      return coarse ? ((32'd1 << (pw - 1)) - 1) : ((32'd1 << pw) - 1);
   endfunction

endpackage

// File: rtl/qe_target.sv
module qe_target
   import qe_pkg::*;
#(
   parameter int ANG_W = 14,
   parameter int PW    = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ANG_W-1:0] angle_i,
   input  logic             vld_i,
   input  logic             coarse_i,
   input  logic [1:0]       hys_i,
   output logic [PW-1:0]    qnt_o,
   output logic             seed_o,
   output logic [PW-1:0]    tgt_o
);
   localparam int SH_F = ANG_W - PW;
   localparam int SH_C = ANG_W - PW + 1;

   logic [PW-1:0] msk, half, qnt, dfw, dbw, mag, tgt_q;
   logic [1:0]    hys;
   logic          init_q, take;

   always_comb begin
      msk  = PW'(grid_mask(PW, coarse_i));
      half = (msk >> 1) + PW'(1);
      qnt  = coarse_i ? PW'(angle_i >> SH_C) : PW'(angle_i >> SH_F);
      dfw  = (qnt - tgt_q) & msk;
      dbw  = (tgt_q - qnt) & msk;
      mag  = (dfw <= half) ? dfw : dbw;
      hys  = hys_steps(hys_i, coarse_i);
      take = vld_i && init_q && (mag > PW'(hys));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= 1'b0;
         tgt_q  <= '0;
      end else if (vld_i && !init_q) begin
         init_q <= 1'b1;
         tgt_q  <= qnt;
      end else if (take) begin
         tgt_q  <= qnt;
      end
   end

   assign qnt_o  = qnt;
   assign seed_o = vld_i && !init_q;
   assign tgt_o  = tgt_q;

endmodule

// File: rtl/qe_stepper.sv
module qe_stepper
   import qe_pkg::*;
#(
   parameter int PW       = 11,
   parameter int TICK_DIV = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          coarse_i,
   input  logic          seed_i,
   input  logic [PW-1:0] qnt_i,
   input  logic [PW-1:0] tgt_i,
   output logic [PW-1:0] pos_o,
   output logic          run_o,
   output logic          tick_o
);
   logic          tick;
   logic [PW-1:0] msk, half, fwd, pos_q, pos_up, pos_dn;
   logic          run_q, go_up;

   generate
      if (TICK_DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(TICK_DIV);
         localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + CW'(1);
         end
         assign tick = (cnt_q == LAST);
      end
   endgenerate

   always_comb begin
      msk    = PW'(grid_mask(PW, coarse_i));
      half   = (msk >> 1) + PW'(1);
      fwd    = (tgt_i - pos_q) & msk;
      go_up  = (fwd <= half);
      pos_up = (pos_q + PW'(1)) & msk;
      pos_dn = (pos_q - PW'(1)) & msk;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         run_q <= 1'b0;
      end else if (seed_i) begin
         pos_q <= qnt_i;
         run_q <= 1'b1;
      end else if (run_q && tick && (fwd != '0)) begin
         pos_q <= go_up ? pos_up : pos_dn;
      end
   end

   assign pos_o  = pos_q;
   assign run_o  = run_q;
   assign tick_o = tick;

endmodule

// File: rtl/qe_phase.sv
module qe_phase
   import qe_pkg::*;
#(
   parameter int PW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] pos_i,
   input  logic          run_i,
   input  logic          coarse_i,
   input  logic          dir_inv_i,
   input  logic          narrow_i,
   input  logic          fault_i,
   output logic          qa_o,
   output logic          qb_o,
   output logic          qi_o
);
   logic [PW-1:0] msk, p;
   logic          ph_a, ph_b, idx;

   always_comb begin
      msk  = PW'(grid_mask(PW, coarse_i));
      p    = pos_i & msk;
      ph_a = p[0] ^ p[1];
      ph_b = p[1];
      idx  = (p == '0) || (!narrow_i && ((p == PW'(1)) || (p == msk)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {qa_o, qb_o, qi_o} <= 3'b000;
      end else if (fault_i) begin
         {qa_o, qb_o, qi_o} <= 3'b111;
      end else if (!run_i) begin
         {qa_o, qb_o, qi_o} <= 3'b000;
      end else begin
         qa_o <= dir_inv_i ? ph_b : ph_a;
         qb_o <= dir_inv_i ? ph_a : ph_b;
         qi_o <= idx;
      end
   end

endmodule

// File: rtl/quad_enc_emu.sv
module quad_enc_emu #(
   parameter int ANG_W    = 14,
   parameter int FINE_RES = 11,
   parameter int TICK_DIV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ANG_W-1:0] angle_i,
   input  logic             angle_vld_i,
   input  logic             res10_i,
   input  logic             dir_inv_i,
   input  logic             idx_narrow_i,
   input  logic [1:0]       hys_code_i,
   input  logic             fault_i,
   output logic             qa_o,
   output logic             qb_o,
   output logic             qi_o
);
   localparam int PW = FINE_RES;

   generate
      if (FINE_RES < 4) begin : g_bad_res
         $error("FINE_RES must be at least 4");
      end
      if (ANG_W < FINE_RES) begin : g_bad_ang
         $error("ANG_W must not be narrower than FINE_RES");
      end
      if (TICK_DIV < 1) begin : g_bad_tick
         $error("TICK_DIV must be at least 1");
      end
   endgenerate

   logic [PW-1:0] qnt_w, tgt_w, pos_w;
   logic          seed_w, run_w, tick_w;

   qe_target #(.ANG_W(ANG_W), .PW(PW)) u_tgt (
      .clk(clk), .rst_n(rst_n), .angle_i(angle_i), .vld_i(angle_vld_i),
      .coarse_i(res10_i), .hys_i(hys_code_i),
      .qnt_o(qnt_w), .seed_o(seed_w), .tgt_o(tgt_w)
   );

   qe_stepper #(.PW(PW), .TICK_DIV(TICK_DIV)) u_step (
      .clk(clk), .rst_n(rst_n), .coarse_i(res10_i), .seed_i(seed_w),
      .qnt_i(qnt_w), .tgt_i(tgt_w),
      .pos_o(pos_w), .run_o(run_w), .tick_o(tick_w)
   );

   qe_phase #(.PW(PW)) u_ph (
      .clk(clk), .rst_n(rst_n), .pos_i(pos_w), .run_i(run_w),
      .coarse_i(res10_i), .dir_inv_i(dir_inv_i), .narrow_i(idx_narrow_i),
      .fault_i(fault_i), .qa_o(qa_o), .qb_o(qb_o), .qi_o(qi_o)
   );

endmodule

// File: rtl/qe_chk.sv
module qe_chk #(
   parameter int PW = 11
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fault_i,
   input logic          dir_inv_i,
   input logic          res10_i,
   input logic          qa_o,
   input logic          qb_o,
   input logic          qi_o,
   input logic          tick_w,
   input logic          run_w,
   input logic [PW-1:0] pos_w
);
   logic [PW-1:0] msk, pos_prev, dpos;

   assign msk  = res10_i ? {1'b0, {(PW-1){1'b1}}} : {PW{1'b1}};
   assign dpos = (pos_w - pos_prev) & msk;

   always_ff @(posedge clk) pos_prev <= pos_w;

   // R9: fault parks every output high on the next clock
   p_fault_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_i |=> (qa_o && qb_o && qi_o));

   // R10: nothing leaves the block before the first valid angle
   p_quiet_before_init_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_w && !fault_i) |=> (!qa_o && !qb_o && !qi_o));

   // R6: position moves only on a step-rate tick
   p_step_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run_w) && (pos_w != pos_prev)) |-> $past(tick_w));

   // R8: every move is one adjacent step, the seam included
   p_unit_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run_w) && (pos_w != pos_prev)) |-> ((dpos == PW'(1)) || (dpos == msk)));

   // R2: A and B never toggle together during normal running
   p_one_phase_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run_w, 2) && !$past(fault_i) && !$past(fault_i, 2) && !fault_i &&
       ($past(dir_inv_i) == $past(dir_inv_i, 2)))
      |-> !((qa_o != $past(qa_o)) && (qb_o != $past(qb_o))));

endmodule

bind quad_enc_emu qe_chk #(.PW(FINE_RES)) u_chk (
   .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .dir_inv_i(dir_inv_i),
   .res10_i(res10_i), .qa_o(qa_o), .qb_o(qb_o), .qi_o(qi_o),
   .tick_w(tick_w), .run_w(run_w), .pos_w(pos_w)
);

// File: tb/tb_quad_enc_emu.sv
module tb_quad_enc_emu;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int CLK_P = 10;
   localparam int TICK  = 4;
   localparam int AW    = 14;
   localparam int FR    = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] angle = '0;
   logic          vld = 1'b0, res10 = 1'b0, dir = 1'b0, narrow = 1'b0, fault = 1'b0;
   logic [1:0]    hys = 2'b11;
   logic          qa, qb, qi;

   int n_chk = 0, n_fail = 0;
   int N = 2048, msk = 2047;
   int exp_tgt = 0;
   bit exp_init = 0;
   int dec_cnt = 0, dec_ph = 0, gap = 0, dec_bad = 0;
   bit dec_on = 0;

   quad_enc_emu #(.ANG_W(AW), .FINE_RES(FR), .TICK_DIV(TICK)) dut (
      .clk(clk), .rst_n(rst_n), .angle_i(angle), .angle_vld_i(vld),
      .res10_i(res10), .dir_inv_i(dir), .idx_narrow_i(narrow),
      .hys_code_i(hys), .fault_i(fault), .qa_o(qa), .qb_o(qb), .qi_o(qi)
   );

   always #(CLK_P/2) clk = ~clk;

   function automatic int phase_of(input logic a, input logic b, input logic d);
      logic aa, bb;
      aa = d ? b : a;
      bb = d ? a : b;
      return {bb, aa ^ bb};
   endfunction

   // R2 table: phase 0..3 -> {A,B} = 00,10,11,01, swapped when dir set
   function automatic int exp_ab(input int p, input logic d);
      logic a, b;
      case (p & 3)
         0: begin a = 0; b = 0; end
         1: begin a = 1; b = 0; end
         2: begin a = 1; b = 1; end
         default: begin a = 0; b = 1; end
      endcase
      return d ? {b, a} : {a, b};
   endfunction

   function automatic int exp_idx(input int p);
      if (p == 0) return 1;
      if (!narrow && (p == 1 || p == N - 1)) return 1;
      return 0;
   endfunction

   // R4/R5 tables
   function automatic int hys_of(input logic [1:0] c, input logic coarse);
      if (!coarse)
         case (c) 2'b00: return 3; 2'b01: return 2; 2'b10: return 1; default: return 0; endcase
      else
         case (c) 2'b00: return 2; 2'b01: return 1; 2'b10: return 0; default: return 3; endcase
   endfunction

   function automatic int cmag(input int d);
      int m;
      m = d & msk;
      return (m <= N / 2) ? m : N - m;
   endfunction

   function automatic int quant(input int a);
      return res10 ? (a >> (AW - FR + 1)) : (a >> (AW - FR));
   endfunction

   function automatic int ang_of(input int s, input int frac);
      int sh;
      sh = res10 ? (AW - FR + 1) : (AW - FR);
      return ((s & msk) << sh) | (frac & ((1 << sh) - 1));
   endfunction

   // continuous quadrature decoder on the outputs
   always @(negedge clk) begin : decoder
      int ph, dl;
      ph  = phase_of(qa, qb, dir);
      gap = gap + 1;
      if (dec_on) begin
         dl = (ph - dec_ph) & 3;
         if (dl != 0) begin
            if (dl == 2) dec_bad = dec_bad + 1;
            else begin
               dec_cnt = (dl == 1) ? dec_cnt + 1 : dec_cnt - 1;
               if (gap < TICK) dec_bad = dec_bad + 1;
            end
            gap = 0;
         end
      end
      dec_ph = ph;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic do_reset(input logic r10, input logic d, input logic nar, input logic [1:0] h);
      rst_n = 1'b0; vld = 1'b0; fault = 1'b0; dec_on = 0; dec_bad = 0;
      res10 = r10; dir = d; narrow = nar; hys = h;
      N = r10 ? 1024 : 2048; msk = N - 1;
      exp_init = 0; exp_tgt = 0;
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
   endtask

   task automatic push(input int a);
      int q;
      q = quant(a);
      if (!exp_init) begin exp_tgt = q; exp_init = 1; end
      else if (cmag(q - exp_tgt) > hys_of(hys, res10)) exp_tgt = q;
      angle = AW'(a); vld = 1'b1;
      cyc(1);
      vld = 1'b0;
   endtask

   task automatic go(input int a);
      int old;
      old = exp_tgt;
      push(a);
      cyc(cmag(exp_tgt - old) * TICK + TICK + 4);
   endtask

   task automatic resync();
      dec_cnt = exp_tgt; dec_ph = phase_of(qa, qb, dir); gap = TICK; dec_on = 1;
   endtask

   task automatic first(input int a);
      push(a);
      chk({qa, qb, qi} == 3'b000, "R10 outputs before first sample", {qa, qb, qi}, 0);
      cyc(1);
      chk({qa, qb} == exp_ab(exp_tgt, dir), "R10 loaded phase", {qa, qb}, exp_ab(exp_tgt, dir));
      resync();
      cyc(2 * TICK + 2);
      chk((dec_cnt & msk) == exp_tgt && dec_bad == 0, "R10 no steps at load", dec_cnt & msk, exp_tgt);
   endtask

   task automatic verify(input string req);
      chk((dec_cnt & msk) == exp_tgt, req, dec_cnt & msk, exp_tgt);
      chk({qa, qb} == exp_ab(exp_tgt, dir), req, {qa, qb}, exp_ab(exp_tgt, dir));
      chk(int'(qi) == exp_idx(exp_tgt), "R3 index level", qi, exp_idx(exp_tgt));
      chk(dec_bad == 0, "R6 illegal or early edge", dec_bad, 0);
   endtask

   initial begin : watchdog
      #(CLK_P * 190000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int c0, h;
      void'($urandom(32'd20240611));

      // R10: quiet after reset
      do_reset(1'b0, 1'b0, 1'b0, 2'b11);
      cyc(10);
      chk({qa, qb, qi} == 3'b000, "R10 reset state", {qa, qb, qi}, 0);

      // R1: fine grid quantisation
      first(14'h1234 | 3);
      chk(exp_tgt == 582 && (dec_cnt & msk) == 582, "R1 fine step index", dec_cnt & msk, 582);

      // R2: A leads on increasing position
      go(ang_of(584, 5));
      verify("R2 phase 0");
      go(ang_of(585, 1));
      chk({qa, qb} == 2'b10, "R2 A leads", {qa, qb}, 2'b10);
      go(ang_of(586, 0));
      chk({qa, qb} == 2'b11, "R2 second step", {qa, qb}, 2'b11);
      go(ang_of(585, 7));
      verify("R2 reverse step");

      // R6: rate limit on a long move
      c0 = dec_cnt;
      push(ang_of(625, 0));
      cyc(20 * TICK);
      chk((dec_cnt - c0) >= 18 && (dec_cnt - c0) <= 21, "R6 steps per tick", dec_cnt - c0, 20);
      cyc(20 * TICK + 8);
      verify("R7 long move settles");

      // R7: large jump and retarget mid-move
      go(ang_of(925, 3));
      verify("R7 jump of 300");
      push(ang_of(1125, 0));
      cyc(50 * TICK);
      push(ang_of(825, 0));
      cyc(400 * TICK);
      verify("R7 retarget mid-move");

      // R8: seam in both directions, R3 index at the seam
      go(ang_of(2046, 0));
      verify("R8 near top");
      go(ang_of(3, 0));
      verify("R8 forward across seam");
      go(ang_of(2045, 2));
      verify("R8 backward across seam");
      go(ang_of(0, 0));
      chk(qi == 1'b1, "R3 index at 0", qi, 1);
      go(ang_of(1, 0));
      chk(qi == 1'b1, "R3 wide index at 1", qi, 1);
      go(ang_of(2047, 0));
      chk(qi == 1'b1, "R3 wide index at N-1", qi, 1);
      go(ang_of(2, 0));
      chk(qi == 1'b0, "R3 index off at 2", qi, 0);

      // R6: half-turn tie counts up
      go(ang_of(0, 0));
      c0 = dec_cnt;
      push(ang_of(1024, 0));
      cyc(3 * TICK);
      chk((dec_cnt - c0) > 0, "R6 tie goes up", dec_cnt - c0, 1);
      cyc(1024 * TICK + 8);
      verify("R6 tie settles");

      // R9: fault forces high, tracking continues
      fault = 1'b1; dec_on = 0;
      cyc(1);
      chk({qa, qb, qi} == 3'b111, "R9 fault high", {qa, qb, qi}, 7);
      push(ang_of(1034, 0));
      cyc(10 * TICK + 8);
      chk({qa, qb, qi} == 3'b111, "R9 fault held", {qa, qb, qi}, 7);
      fault = 1'b0;
      cyc(1);
      chk({qa, qb} == exp_ab(exp_tgt, dir), "R9 tracked under fault", {qa, qb}, exp_ab(exp_tgt, dir));
      resync();

      // R3: narrow index
      do_reset(1'b0, 1'b0, 1'b1, 2'b11);
      first(ang_of(5, 0));
      go(ang_of(1, 0));
      chk(qi == 1'b0, "R3 narrow index off at 1", qi, 0);
      go(ang_of(0, 0));
      chk(qi == 1'b1, "R3 narrow index on at 0", qi, 1);

      // R2: swapped phases
      do_reset(1'b0, 1'b1, 1'b0, 2'b11);
      first(ang_of(8, 0));
      go(ang_of(9, 0));
      chk({qa, qb} == 2'b01, "R2 dir swap B leads", {qa, qb}, 2'b01);

      // R4 / R5: every code at both grids, inside and just beyond the band
      for (int r = 0; r < 2; r++) begin
         for (int c = 0; c < 4; c++) begin
            do_reset(r[0], 1'b0, 1'b0, c[1:0]);
            first(ang_of(50, 1));
            h = hys_of(c[1:0], r[0]);
            go(ang_of(50 + h, 0));
            chk((dec_cnt & msk) == 50, r ? "R5 inside band" : "R4 inside band", dec_cnt & msk, 50);
            go(ang_of(51 + h, 0));
            chk((dec_cnt & msk) == 51 + h, r ? "R5 beyond band" : "R4 beyond band", dec_cnt & msk, 51 + h);
            go(ang_of(50 + h, 0) );
            verify(r ? "R5 return" : "R4 return");
         end
      end

      // R1: coarse grid full scale
      do_reset(1'b1, 1'b0, 1'b0, 2'b10);
      first(14'h3FFF);
      chk((dec_cnt & msk) == 1023, "R1 coarse full scale", dec_cnt & msk, 1023);

      // R7: random walks with random configurations
      for (int k = 0; k < 4; k++) begin
         do_reset(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
         first(int'($urandom_range(0, 16383)));
         for (int i = 0; i < 25; i++) begin
            int s;
            s = exp_tgt + int'($urandom_range(0, 300)) - 150;
            go(ang_of(s, int'($urandom_range(0, 15))));
            verify("R7 random walk");
         end
      end

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule